// File: doc/BRIEF.md
# Lane Enable Mask Generator

This block converts a compact enable request, a 2-bit mode together with a 5-bit value, into one enable bit per lane of a vector multiply-accumulate datapath. A vector holds up to 32 lanes. A separate element-width input sets how many of those lanes are active: 8, 16 or 32. One copy of the block drives the lane enables of the X operand, and a second copy drives those of the Y operand.

All four modes read the same value field, and each mode gives it a different meaning. Mode 0 reads the value as a parity selector. Mode 1 reads it as the index of a single lane. Mode 2 reads it as the length of a run that starts at lane 0. Mode 3 reads it as the length of a run that ends at the highest active lane. Lanes at or above the active count are never enabled.

The mask is computed combinationally. A build parameter can add one output register, which delays the mask by one clock cycle and clears it to zero while reset is held. The block has no handshake. Its inputs are control fields that are sampled every cycle, and `mask_o` simply follows them.

Top module: `lane_mask_gen`

## Requirements
- R1: The element-width input `width_i` sets the active count: 0 gives 8 lanes, 1 gives 16 lanes, and both 2 and 3 give 32 lanes. Bit k of `mask_o` enables lane k. Every bit at or above the active count is 0 in every mode.
- R2: In mode 0 with value 0, every active lane is enabled.
- R3: In mode 0, value 1 enables only the odd active lanes, and value 2 enables only the even active lanes.
- R4: In mode 0, any value from 3 to 31 gives an all-zero mask.
- R5: In mode 1, when the value is below the active count, exactly one bit is set, the bit whose index equals the value.
- R6: In mode 1, when the value is at or above the active count, the mask is all zero.
- R7: In mode 2, when the value N satisfies 0 < N < active count, lanes 0 to N-1 are enabled and no others.
- R8: In modes 2 and 3, a value of 0, or a value at or above the active count, enables every active lane.
- R9: In mode 3, when the value N satisfies 0 < N < active count C, lanes C-N to C-1 are enabled and no others.
- R10: When built with REG_OUT=1, `mask_o` is 0 while `rst_n` is low. After reset, `mask_o` shows the combinational mask for the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low reset; clears the output register |
| mode_i | input | 2 | Enable mode: 0 parity, 1 single lane, 2 leading run, 3 trailing run |
| value_i | input | 5 | Enable value; its meaning depends on `mode_i` |
| width_i | input | 2 | Active lane count: 0 gives 8, 1 gives 16, 2 or 3 gives 32 |
| mask_o | output | 32 | Per-lane enable vector; bit k enables lane k |

## Verification
The bench builds two instances, both with the default 32-lane geometry: one combinational (REG_OUT=0) and one registered (REG_OUT=1). At this size the input space is only 512 points, 4 widths by 4 modes by 32 values. The bench therefore sweeps all of it against an arithmetic model made of shifts and subtractions. The sweep reaches every zero case and every out-of-range case of each mode, and checks each of them at every lane count. The registered instance is compared on every point against the same model, one clock edge later, and its reset value is checked as well.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
  typedef enum logic [1:0] {
    EN_PARITY = 2'd0,
    EN_SINGLE = 2'd1,
    EN_LEAD   = 2'd2,
    EN_TRAIL  = 2'd3
  } en_mode_e;

  typedef enum logic [1:0] {
    LW_QUARTER  = 2'd0,
    LW_HALF     = 2'd1,
    LW_FULL     = 2'd2,
    LW_FULL_ALT = 2'd3
  } lane_width_e;
endpackage

// File: rtl/lane_count_dec.sv
module lane_count_dec
  import lane_mask_pkg::*;
#(
  parameter int MAX_LANES = 32,
  parameter int CNT_W     = $clog2(MAX_LANES) + 1
) (
  input  lane_width_e          width_i,
  output logic [CNT_W-1:0]     count_o,
  output logic [MAX_LANES-1:0] active_o
);
  localparam logic [CNT_W-1:0] QUARTER_CNT = CNT_W'(MAX_LANES / 4);
  localparam logic [CNT_W-1:0] HALF_CNT    = CNT_W'(MAX_LANES / 2);
  localparam logic [CNT_W-1:0] FULL_CNT    = CNT_W'(MAX_LANES);

  always_comb begin
    unique case (width_i)
      LW_QUARTER: count_o = QUARTER_CNT;
      LW_HALF:    count_o = HALF_CNT;
      default:    count_o = FULL_CNT;
    endcase
  end

  for (genvar k = 0; k < MAX_LANES; k++) begin : g_active
    localparam logic [CNT_W-1:0] LANE = CNT_W'(k);
    assign active_o[k] = (LANE < count_o);
  end
endmodule

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen
  import lane_mask_pkg::*;
#(
  parameter int MAX_LANES = 32,
  parameter int VAL_W     = 5,
  parameter int CNT_W     = $clog2(MAX_LANES) + 1
) (
  input  en_mode_e             mode_i,
  input  logic [VAL_W-1:0]     value_i,
  input  logic [CNT_W-1:0]     count_i,
  input  logic [MAX_LANES-1:0] active_i,
  output logic [MAX_LANES-1:0] mask_o
);
  logic [CNT_W-1:0] val_ext;
  logic [CNT_W-1:0] trail_start;
  logic             run_full;

  assign val_ext     = CNT_W'(value_i);
  assign run_full    = (value_i == '0) || (val_ext >= count_i);
  assign trail_start = count_i - val_ext;

  for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
    localparam logic [CNT_W-1:0] LANE = CNT_W'(k);
    localparam logic             IS_ODD = (k % 2) == 1;
    logic raw;

    always_comb begin
      unique case (mode_i)
        EN_PARITY: begin
          if (value_i == VAL_W'(0))      raw = 1'b1;
          else if (value_i == VAL_W'(1)) raw = IS_ODD;
          else if (value_i == VAL_W'(2)) raw = !IS_ODD;
          else                           raw = 1'b0;
        end
        EN_SINGLE: raw = (val_ext == LANE);
        EN_LEAD:   raw = run_full || (LANE < val_ext);
        EN_TRAIL:  raw = run_full || (LANE >= trail_start);
        default:   raw = 1'b0;
      endcase
    end

    assign mask_o[k] = raw & active_i[k];
  end
endmodule

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
  import lane_mask_pkg::*;
#(
  parameter int MAX_LANES = 32,
  parameter int VAL_W     = 5,
  parameter bit REG_OUT   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_i,
  input  logic [VAL_W-1:0]     value_i,
  input  logic [1:0]           width_i,
  output logic [MAX_LANES-1:0] mask_o
);
  localparam int CNT_W = $clog2(MAX_LANES) + 1;

  logic [CNT_W-1:0]     lane_cnt;
  logic [MAX_LANES-1:0] active;
  logic [MAX_LANES-1:0] mask_nxt;

  lane_count_dec #(.MAX_LANES(MAX_LANES), .CNT_W(CNT_W)) u_count (
    .width_i  (lane_width_e'(width_i)),
    .count_o  (lane_cnt),
    .active_o (active)
  );

  lane_pattern_gen #(.MAX_LANES(MAX_LANES), .VAL_W(VAL_W), .CNT_W(CNT_W)) u_pattern (
    .mode_i   (en_mode_e'(mode_i)),
    .value_i  (value_i),
    .count_i  (lane_cnt),
    .active_i (active),
    .mask_o   (mask_nxt)
  );

  if (REG_OUT) begin : g_reg
    logic [MAX_LANES-1:0] mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_nxt;
    end
    assign mask_o = mask_q;

    // R10
    reg_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mask_o == $past(mask_nxt)));
  end else begin : g_comb
    assign mask_o = mask_nxt;
  end

  // R1
  quarter_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_i == 2'd0) |-> ((mask_nxt >> (MAX_LANES / 4)) == '0));

  // R5
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1) |-> $onehot0(mask_nxt));

  // R3
  odd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && value_i == VAL_W'(1)) |->
      ((mask_nxt & {(MAX_LANES / 2){2'b01}}) == '0));

  // R7
  lead_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && value_i != '0 && CNT_W'(value_i) < lane_cnt) |->
      ($countones(mask_nxt) == int'(value_i) && mask_nxt[0]));

  // R9
  trail_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3 && value_i != '0 && CNT_W'(value_i) < lane_cnt) |->
      ($countones(mask_nxt) == int'(value_i) && mask_nxt[lane_cnt - 1'b1]));
endmodule

// File: tb/lane_mask_gen_bench.sv
module lane_mask_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode_i = '0;
  logic [4:0]        value_i = '0;
  logic [1:0]        width_i = '0;
  logic [LANES-1:0]  mask_c;
  logic [LANES-1:0]  mask_r;
  int                checks = 0;
  int                errors = 0;
  bit                done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lane_mask_gen #(.MAX_LANES(LANES), .VAL_W(5), .REG_OUT(1'b0)) u_lane_mask_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .value_i(value_i),
    .width_i(width_i), .mask_o(mask_c)
  );

  lane_mask_gen #(.MAX_LANES(LANES), .VAL_W(5), .REG_OUT(1'b1)) u_lane_mask_gen_reg (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .value_i(value_i),
    .width_i(width_i), .mask_o(mask_r)
  );

  function automatic int lanes_of(int w);
    return (w == 0) ? 8 : (w == 1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] model(int w, int m, int v);
    int          c = lanes_of(w);
    logic [63:0] act = (64'd1 << c) - 64'd1;
    logic [63:0] r;
    bit          full = (v == 0) || (v >= c);
    case (m)
      0: r = (v == 0) ? act : (v == 1) ? (act & 64'hAAAA_AAAA)
           : (v == 2) ? (act & 64'h5555_5555) : 64'd0;
      1: r = (v < c) ? (64'd1 << v) : 64'd0;
      2: r = full ? act : ((64'd1 << v) - 64'd1);
      default: r = full ? act : (act & ~((64'd1 << (c - v)) - 64'd1));
    endcase
    return r[31:0];
  endfunction

  function automatic string tag_of(int w, int m, int v);
    int c = lanes_of(w);
    bit full = (v == 0) || (v >= c);
    if (w == 3) return "R1";
    case (m)
      0: return (v == 0) ? "R2" : (v <= 2) ? "R3" : "R4";
      1: return (v < c) ? "R5" : "R6";
      2: return full ? "R8" : "R7";
      default: return full ? "R8" : "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", mask_r, 32'h0);  // registered output held at zero in reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < 4; w++) begin
      for (int m = 0; m < 4; m++) begin
        for (int v = 0; v < 32; v++) begin
          width_i = w[1:0];
          mode_i  = m[1:0];
          value_i = v[4:0];
          @(negedge clk);
          check(tag_of(w, m, v), mask_c, model(w, m, v));
          check("R10", mask_r, model(w, m, v));
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule